// File: doc/BRIEF.md
# Register-or-Literal Integer ALU

This block is the integer execution unit for the two operate classes of a 32-bit processor: the class that takes both operands from registers and the class that takes its second operand from a 16-bit instruction literal. The issuing stage presents the 6-bit opcode, operand A, the register operand B and the literal together with a one-cycle `start` pulse. The unit decodes the function from the low opcode bits, picks the second operand from bit 4 of the opcode, and returns a 32-bit result with no condition flags.

Add, subtract, the bitwise group, the signed comparisons and the shifts finish combinationally: `done` and `result` are valid in the cycle in which `start` is high. Multiply and divide are handed to a shared radix-2 iterative engine. It raises `busy` for the whole operation and reports `done` a fixed number of cycles later. A start that arrives while the engine is busy is dropped, so the issuing stage must watch `busy` before it presents the next operation.

Top module: `rl_alu`

## Requirements
- R1: An opcode is legal only when bit 5 is 1. Bit 4 set selects the 16-bit literal, sign-extended to 32 bits (for logical functions too), as operand B; bit 4 clear selects `op_b`, and the literal is then ignored. Bits 3:0 are the function code: add 0x0, sub 0x1, mul 0x2, div 0x3, equal 0x4, less 0x5, less-or-equal 0x6, and 0x8, or 0x9, xor 0xA, xnor 0xB, shift-left 0xC, logical shift-right 0xD, arithmetic shift-right 0xE.
- R2: Add and subtract return the sum or difference modulo 2^32 and give no carry, borrow or overflow indication.
- R3: The bitwise functions return A&B, A|B, A^B and ~(A^B).
- R4: The three comparisons treat A and B as signed two's complement numbers and return exactly 1 when true and 0 when false.
- R5: A shift moves A by the value of bits 4:0 of B (0 to 31 positions). Left and logical-right shifts fill with zeros, and the arithmetic right shift fills with bit 31 of A.
- R6: Every legal function other than multiply and divide raises `done` with a valid `result` in the same cycle as the accepted `start`.
- R7: Multiply returns the low 32 bits of the product, with `done` high exactly 33 cycles after the cycle of the accepted `start`.
- R8: Divide is signed and truncates toward zero, with the same latency as multiply. The quotient of 0x80000000 by -1 is 0x80000000.
- R9: Division by zero returns 0xFFFFFFFF and completes with the normal divide latency and no other indication.
- R10: Function codes 0x7 and 0xF, and any opcode with bit 5 clear, raise `illegal` and `done` in the start cycle with `result` 0.
- R11: `busy` is high from the cycle after an accepted multiply or divide start through its `done` cycle. A `start` seen while `busy` is high is ignored: it yields no `done` and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, valid for one cycle |
| opcode | input | 6 | Class bits 5:4 and function code bits 3:0 |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Register operand B |
| literal | input | 16 | Instruction literal, two's complement |
| done | output | 1 | Result valid this cycle |
| busy | output | 1 | Iterative engine occupied |
| illegal | output | 1 | Start carried an unsupported opcode |
| result | output | 32 | Operation result, valid when done is high |

## Verification
Completion of an iterative multiply or divide can coincide with a new `start` that is presented in the same cycle, since the engine still reports `busy` in its `done` cycle. The bench provokes this by holding `start` high with a single-cycle add for every cycle of a pending divide, including its final cycle. The scoreboard then expects exactly one `done`: it must carry the quotient, arrive at the 33-cycle latency, and no extra completion may follow. An ordinary operation issued afterwards confirms that the unit accepts work again.

// File: rtl/rl_alu_pkg.sv
package rl_alu_pkg;

    localparam logic [3:0] FN_ADD  = 4'h0;
    localparam logic [3:0] FN_SUB  = 4'h1;
    localparam logic [3:0] FN_MUL  = 4'h2;
    localparam logic [3:0] FN_DIV  = 4'h3;
    localparam logic [3:0] FN_CEQ  = 4'h4;
    localparam logic [3:0] FN_CLT  = 4'h5;
    localparam logic [3:0] FN_CLE  = 4'h6;
    localparam logic [3:0] FN_BAD0 = 4'h7;
    localparam logic [3:0] FN_AND  = 4'h8;
    localparam logic [3:0] FN_OR   = 4'h9;
    localparam logic [3:0] FN_XOR  = 4'hA;
    localparam logic [3:0] FN_XNOR = 4'hB;
    localparam logic [3:0] FN_SHL  = 4'hC;
    localparam logic [3:0] FN_SHR  = 4'hD;
    localparam logic [3:0] FN_SRA  = 4'hE;
    localparam logic [3:0] FN_BAD1 = 4'hF;

    typedef struct packed {
        logic       legal;
        logic       use_lit;
        logic       is_long;
        logic       is_div;
        logic [3:0] fn;
    } alu_dec_t;

endpackage

// File: rtl/rl_decode.sv
module rl_decode
    import rl_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int LIT_W = 16
) (
    input  logic [5:0]       opcode,
    input  logic [W-1:0]     op_b,
    input  logic [LIT_W-1:0] literal,
    output alu_dec_t         dec,
    output logic [W-1:0]     b_eff
);
    localparam int EXT_W = W - LIT_W;

    always_comb begin
        dec.fn      = opcode[3:0];
        dec.use_lit = opcode[4];
        dec.legal   = opcode[5] && (opcode[3:0] != FN_BAD0) && (opcode[3:0] != FN_BAD1);
        dec.is_div  = (opcode[3:0] == FN_DIV);
        dec.is_long = (opcode[3:0] == FN_MUL) || (opcode[3:0] == FN_DIV);
        b_eff = opcode[4] ? {{EXT_W{literal[LIT_W-1]}}, literal} : op_b;
    end

endmodule

// File: rtl/rl_simple_unit.sv
module rl_simple_unit
    import rl_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] amt;
    logic            lt;
    logic            eq;

    always_comb begin
        amt = b[SH_W-1:0];
        lt  = $signed(a) < $signed(b);
        eq  = (a == b);
        unique case (fn)
            FN_ADD:  res = a + b;
            FN_SUB:  res = a - b;
            FN_CEQ:  res = {{(W-1){1'b0}}, eq};
            FN_CLT:  res = {{(W-1){1'b0}}, lt};
            FN_CLE:  res = {{(W-1){1'b0}}, lt | eq};
            FN_AND:  res = a & b;
            FN_OR:   res = a | b;
            FN_XOR:  res = a ^ b;
            FN_XNOR: res = ~(a ^ b);
            FN_SHL:  res = a << amt;
            FN_SHR:  res = a >> amt;
            FN_SRA:  res = $unsigned($signed(a) >>> amt);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rl_iter_unit.sv
module rl_iter_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         go_div,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] res
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    typedef struct packed {
        logic             busy;
        logic             is_div;
        logic             neg;
        logic             dz;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     acc;
        logic [W-1:0]     x;
        logic [W-1:0]     y;
    } it_st_t;

    it_st_t st_d, st_q;
    logic [W-1:0] rem_sh;

    always_comb begin
        st_d   = st_q;
        fin    = st_q.busy && (st_q.cnt == LAST);
        rem_sh = {st_q.acc[W-2:0], st_q.x[W-1]};
        if (go) begin
            st_d.busy   = 1'b1;
            st_d.is_div = go_div;
            st_d.cnt    = '0;
            st_d.acc    = '0;
            if (go_div) begin
                st_d.neg = a[W-1] ^ b[W-1];
                st_d.dz  = (b == '0);
                st_d.x   = a[W-1] ? -a : a;
                st_d.y   = b[W-1] ? -b : b;
            end else begin
                st_d.neg = 1'b0;
                st_d.dz  = 1'b0;
                st_d.x   = a;
                st_d.y   = b;
            end
        end else if (st_q.busy) begin
            if (fin) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.is_div) begin
                    if (rem_sh >= st_q.y) begin
                        st_d.acc = rem_sh - st_q.y;
                        st_d.x   = {st_q.x[W-2:0], 1'b1};
                    end else begin
                        st_d.acc = rem_sh;
                        st_d.x   = {st_q.x[W-2:0], 1'b0};
                    end
                end else begin
                    if (st_q.y[0]) st_d.acc = st_q.acc + st_q.x;
                    st_d.x = st_q.x << 1;
                    st_d.y = st_q.y >> 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        busy = st_q.busy;
        if (!st_q.is_div)  res = st_q.acc;
        else if (st_q.dz)  res = '1;
        else if (st_q.neg) res = -st_q.x;
        else               res = st_q.x;
    end

endmodule

// File: rtl/rl_alu.sv
module rl_alu
    import rl_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int LIT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       opcode,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [LIT_W-1:0] literal,
    output logic             done,
    output logic             busy,
    output logic             illegal,
    output logic [W-1:0]     result
);
    alu_dec_t     dec;
    logic [W-1:0] b_eff;
    logic [W-1:0] simple_res;
    logic [W-1:0] iter_res;
    logic         iter_busy;
    logic         iter_fin;
    logic         accept;
    logic         go_long;
    logic         go_short;

    rl_decode #(.W(W), .LIT_W(LIT_W)) i_decode (
        .opcode  (opcode),
        .op_b    (op_b),
        .literal (literal),
        .dec     (dec),
        .b_eff   (b_eff)
    );

    rl_simple_unit #(.W(W)) i_simple (
        .fn  (dec.fn),
        .a   (op_a),
        .b   (b_eff),
        .res (simple_res)
    );

    always_comb begin
        accept   = start && !iter_busy;
        go_long  = accept && dec.legal && dec.is_long;
        go_short = accept && dec.legal && !dec.is_long;
    end

    rl_iter_unit #(.W(W)) i_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go_long),
        .go_div (dec.is_div),
        .a      (op_a),
        .b      (b_eff),
        .busy   (iter_busy),
        .fin    (iter_fin),
        .res    (iter_res)
    );

    always_comb begin
        busy    = iter_busy;
        illegal = accept && !dec.legal;
        done    = iter_fin || go_short || illegal;
        if (iter_fin)      result = iter_res;
        else if (go_short) result = simple_res;
        else               result = '0;
    end

endmodule

// File: rtl/rl_alu_chk.sv
module rl_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [5:0]   opcode,
    input logic         done,
    input logic         busy,
    input logic         illegal,
    input logic [W-1:0] result
);
    localparam int LW = $clog2(W + 4);
    localparam logic [LW-1:0] LAT = LW'(W + 1);

    logic          take;
    logic          take_long;
    logic          take_cmp;
    logic          take_short;
    logic [LW-1:0] lat_q;

    always_comb begin
        take       = start && !busy && opcode[5];
        take_long  = take && (opcode[3:0] == 4'h2 || opcode[3:0] == 4'h3);
        take_cmp   = take && (opcode[3:0] == 4'h4 || opcode[3:0] == 4'h5 || opcode[3:0] == 4'h6);
        take_short = take && !take_long && opcode[3:0] != 4'h7 && opcode[3:0] != 4'hF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             lat_q <= '0;
        else if (take_long)     lat_q <= LW'(1);
        else if (lat_q != '0)   lat_q <= done ? '0 : lat_q + 1'b1;
    end

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && result == '0)); // R10
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        take_cmp |-> (done && result[W-1:1] == '0)); // R4
    AST_SHORT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_short |-> (done && !illegal)); // R6
    AST_LONG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q != '0) |-> (done == (lat_q == LAT))); // R7
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        take_long |=> busy); // R11
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |=> !busy); // R11

endmodule

bind rl_alu rl_alu_chk #(.W(W)) i_rl_alu_chk (.*);

// File: tb/test_rl_alu.sv
`timescale 1ns/1ps
module test_rl_alu;
    localparam int W   = 32;
    localparam int LAT = W + 1;

    typedef struct {
        logic [31:0] res;
        logic        ill;
        int          lat;
        int          t0;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] literal = '0;
    logic        done, busy, illegal;
    logic [31:0] result;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rl_alu i_rl_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .literal(literal),
        .done(done), .busy(busy), .illegal(illegal), .result(result)
    );

    function automatic logic [31:0] model(input logic [3:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: return a * b;
            4'h3: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
                return $unsigned($signed(a) / $signed(b));
            end
            4'h4: return {31'd0, a == b};
            4'h5: return {31'd0, $signed(a) < $signed(b)};
            4'h6: return {31'd0, $signed(a) <= $signed(b)};
            4'h8: return a & b;
            4'h9: return a | b;
            4'hA: return a ^ b;
            4'hB: return ~(a ^ b);
            4'hC: return a << b[4:0];
            4'hD: return a >> b[4:0];
            4'hE: return $unsigned($signed(a) >>> b[4:0]);
            default: return 32'd0;
        endcase
    endfunction

    task automatic issue(input logic [5:0] opc, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] lit, input string tag);
        exp_t e;
        logic [31:0] bv;
        @(negedge clk);
        while (busy) @(negedge clk);
        bv = opc[4] ? {{16{lit[15]}}, lit} : b;
        e.ill = !opc[5] || opc[3:0] == 4'h7 || opc[3:0] == 4'hF;
        e.res = e.ill ? 32'd0 : model(opc[3:0], a, bv);
        e.lat = (!e.ill && (opc[3:0] == 4'h2 || opc[3:0] == 4'h3)) ? LAT : 0;
        e.t0  = cyc;
        e.tag = tag;
        sb.push_back(e);
        start = 1'b1; opcode = opc; op_a = a; op_b = b; literal = lit;
        @(negedge clk);
        start = 1'b0;
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && done) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected done: result=%h expected no completion", result);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result !== e.res || illegal !== e.ill || (cyc - e.t0) != e.lat) begin
                    n_bad++;
                    $display("FAIL %s: result=%h ill=%b lat=%0d expected result=%h ill=%b lat=%0d",
                             e.tag, result, illegal, cyc - e.t0, e.res, e.ill, e.lat);
                end
            end
        end
    end

    task automatic chk_idle(input string tag);
        n_chk++;
        if (done !== 1'b0 || busy !== 1'b0 || illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: done=%b busy=%b illegal=%b expected 0 0 0", tag, done, busy, illegal);
        end
    endtask

    function automatic logic [5:0] rop(input logic [3:0] fn); return {2'b10, fn}; endfunction
    function automatic logic [5:0] lop(input logic [3:0] fn); return {2'b11, fn}; endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        #2 chk_idle("R6 reset state");
        rst_n = 1'b1;
        @(negedge clk); #2 chk_idle("R11 idle after reset");

        // R1 operand selection and sign extension
        issue(lop(4'h0), 32'd10, 32'hDEAD_BEEF, 16'hFFFF, "R1 literal add -1");
        issue(lop(4'h8), 32'hFFFF_FFFF, 32'd0, 16'h8000, "R1 literal and sign-extended");
        issue(rop(4'h0), 32'd5, 32'd7, 16'h1234, "R1 register form ignores literal");
        // R2 wrap, no flags
        issue(rop(4'h0), 32'h7FFF_FFFF, 32'd1, 16'h0, "R2 add wrap");
        issue(lop(4'h1), 32'd0, 32'd0, 16'h0001, "R2 sub borrow wrap");
        // R3 bitwise
        issue(rop(4'h8), 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, "R3 and");
        issue(rop(4'h9), 32'hF0F0_1234, 32'h0F00_00FF, 16'h0, "R3 or");
        issue(rop(4'hA), 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, "R3 xor");
        issue(lop(4'hB), 32'h0000_00FF, 32'd0, 16'h00F0, "R3 xnor literal");
        // R4 signed compare
        issue(rop(4'h5), 32'hFFFF_FFFF, 32'd1, 16'h0, "R4 lt negative");
        issue(rop(4'h5), 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "R4 lt extremes");
        issue(rop(4'h6), 32'd9, 32'd9, 16'h0, "R4 le equal");
        issue(lop(4'h4), 32'd3, 32'd0, 16'h0004, "R4 eq false");
        issue(lop(4'h6), 32'd1, 32'd0, 16'hFFFF, "R4 le false vs -1");
        // R5 shifts
        issue(rop(4'hC), 32'h0000_0003, 32'd33, 16'h0, "R5 shl count masked");
        issue(rop(4'hE), 32'h8000_0000, 32'd31, 16'h0, "R5 sra fill sign");
        issue(rop(4'hD), 32'h8000_0000, 32'd31, 16'h0, "R5 shr zero fill");
        issue(lop(4'hD), 32'h1234_5678, 32'd0, 16'h0000, "R5 shift by zero");
        // R7 multiply
        issue(rop(4'h2), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, "R7 mul -1*-1");
        issue(lop(4'h2), 32'h1234_5678, 32'd0, 16'hFFFD, "R7 mul literal -3");
        // R8 divide
        issue(rop(4'h3), 32'hFFFF_FFF9, 32'd2, 16'h0, "R8 div -7/2");
        issue(lop(4'h3), 32'd7, 32'd0, 16'hFFFE, "R8 div 7/-2");
        issue(rop(4'h3), 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, "R8 div min/-1");
        // R9 divide by zero
        issue(rop(4'h3), 32'hFFFF_FFF9, 32'd0, 16'h0, "R9 div by zero register");
        issue(lop(4'h3), 32'd100, 32'd5, 16'h0000, "R9 div by zero literal");
        // R10 illegal
        issue(rop(4'h7), 32'd1, 32'd2, 16'h0, "R10 function 7");
        issue(lop(4'hF), 32'd1, 32'd2, 16'h0, "R10 function F");
        issue(6'h18, 32'd1, 32'd2, 16'h0, "R10 class bit clear");

        // R11 starts while busy are dropped, including the completion cycle
        issue(rop(4'h3), 32'd1000, 32'd7, 16'h0, "R11 pending divide result");
        while (busy) begin
            start = 1'b1; opcode = rop(4'h0); op_a = 32'd1; op_b = 32'd1;
            @(negedge clk);
        end
        start = 1'b0;
        issue(rop(4'h1), 32'd50, 32'd8, 16'h0, "R11 accepts after release");

        // R6 mixed pseudo-random traffic
        for (int i = 0; i < 300; i++) begin
            logic [3:0] f;
            f = 4'($urandom_range(0, 14));
            if (f == 4'h7) f = 4'h9;
            issue({1'b1, 1'($urandom_range(0, 1)), f}, $urandom, $urandom, 16'($urandom), "R6 mixed traffic");
        end

        repeat (LAT + 4) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R6 missing completions: pending=%0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule